// File: doc/BRIEF.md
# Clock Status-Change Interrupt Unit

This block watches two clock-health indicators and latches a sticky flag each time either indicator changes level, in either direction. The first indicator is the PLL lock status. It is taken from a raw, asynchronous lock input through a flop synchronizer. The second is an oscillator-ready status that the block derives itself. It is held low while the oscillator is switched off or the chip is in full stop mode. With the oscillator on, it comes up only once lock has been seen. After that it stays up until the oscillator is switched off or stop mode is entered.

Each flag has a local enable. The interrupt request for a source is the flag ANDed with its enable. A flag is recorded even while its enable is low. A small register-style write port loads the two enables and clears flags by writing ones. The block carries no streamed data, so every pin is a plain level or strobe. The write port has no back-pressure: a strobe is taken in the cycle it is seen.

Top module: `clkmon_irq_unit`

## Requirements
- R1: After reset, all six outputs and both local enables are 0.
- R2: `lock_st` follows `lock_raw` through a two-stage synchronizer, so it shows a new level two rising edges after the input changes.
- R3: `lock_flag` becomes 1 on the edge after `lock_st` changes, whether it rises or falls.
- R4: Writing with `wr_sel`=1 clears `lock_flag` where `wr_data[0]`=1 and clears `osc_flag` where `wr_data[1]`=1. Data bits at 0 leave their flag unchanged.
- R5: When a status change and a clear of the same flag fall in the same cycle, the flag stays 1.
- R6: Writing with `wr_sel`=0 loads the lock enable from `wr_data[0]` and the oscillator enable from `wr_data[1]`. Each `*_irq` output is 1 exactly when its flag and its enable are both 1. Flags still set while their enable is 0.
- R7: One edge after `osc_en`=0 or `full_stop`=1 is seen, `osc_rdy` is 0, and it stays 0 while either condition holds.
- R8: With `osc_en`=1 and `full_stop`=0, `osc_rdy` rises one edge after `lock_st` is seen at 1. It never rises while `lock_st` is 0. Once up, it stays up if lock is later lost.
- R9: `osc_flag` becomes 1 on the edge after `osc_rdy` changes in either direction, including a drop forced by stop mode or by switching the oscillator off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_raw | input | 1 | Unsynchronized PLL lock indicator |
| osc_en | input | 1 | Oscillator enable |
| full_stop | input | 1 | Full stop mode active |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: enable register, 1: flag clear register |
| wr_data | input | 2 | Bit 0 lock source, bit 1 oscillator source |
| lock_st | output | 1 | Synchronized lock status |
| osc_rdy | output | 1 | Qualified oscillator-ready status |
| lock_flag | output | 1 | Sticky lock-change flag |
| osc_flag | output | 1 | Sticky oscillator-status flag |
| lock_irq | output | 1 | Lock interrupt request |
| osc_irq | output | 1 | Oscillator interrupt request |

## Verification
The bench brings lock up and down with the oscillator already on and also with it off. Comparing the two runs separates the lock-gated rise of oscillator-ready from its forced drops. Those drops are caused once by clearing the enable and once by entering stop mode. The oscillator is also switched on while lock is low, which shows that ready waits for lock and does not follow the enable alone. Clears are issued on quiet cycles and on cycles that carry a fresh change, which separates a plain clear from set-wins-over-clear. The requests are observed with the enables low and high, which shows that a masked flag is still recorded.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int NSRC     = 2;
  localparam int SRC_LOCK = 0;
  localparam int SRC_OSC  = 1;

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_CLEAR  = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkmon_osc_qual.sv
module clkmon_osc_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic full_stop,
  input  logic lock_st,
  output logic osc_rdy
);
  logic rdy_q;

  // Ready needs lock to come up, then holds until the oscillator goes away.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= osc_en && !full_stop && (rdy_q || lock_st);
  end

  assign osc_rdy = rdy_q;

  assert_forced_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en || full_stop) |=> !osc_rdy);

  assert_rise_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_rdy) |-> $past(lock_st));
endmodule

// File: rtl/clkmon_flag.sv
module clkmon_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic status,
  input  logic clr,
  output logic flag
);
  logic prev_q;
  logic flag_q;
  logic changed;

  assign changed = status ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= status;
      if (changed)  flag_q <= 1'b1;  // a fresh change beats a clear
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;

  // R3 and R9: any change of the watched status sets the flag.
  assert_set_on_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status != $past(status)) |=> flag);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && status == $past(status)) |=> !flag);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && status != $past(status)) |=> flag);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && status == $past(status)) |=> $stable(flag));
endmodule

// File: rtl/clkmon_irq_unit.sv
module clkmon_irq_unit
  import clkmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_raw,
  input  logic       osc_en,
  input  logic       full_stop,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [1:0] wr_data,
  output logic       lock_st,
  output logic       osc_rdy,
  output logic       lock_flag,
  output logic       osc_flag,
  output logic       lock_irq,
  output logic       osc_irq
);
  logic [NSRC-1:0] status_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] flag_vec;
  logic [NSRC-1:0] ie_q;
  logic            wr_enable;
  logic            wr_clear;

  assign wr_enable = wr_en && (wr_sel == SEL_ENABLE);
  assign wr_clear  = wr_en && (wr_sel == SEL_CLEAR);

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (lock_raw),
    .q     (lock_st)
  );

  clkmon_osc_qual u_osc_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_en    (osc_en),
    .full_stop (full_stop),
    .lock_st   (lock_st),
    .osc_rdy   (osc_rdy)
  );

  assign status_vec[SRC_LOCK] = lock_st;
  assign status_vec[SRC_OSC]  = osc_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ie_q <= '0;
    else if (wr_enable) ie_q <= wr_data[NSRC-1:0];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign clr_vec[i] = wr_clear && wr_data[i];
    clkmon_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status_vec[i]),
      .clr    (clr_vec[i]),
      .flag   (flag_vec[i])
    );
  end

  assign lock_flag = flag_vec[SRC_LOCK];
  assign osc_flag  = flag_vec[SRC_OSC];
  assign lock_irq  = flag_vec[SRC_LOCK] & ie_q[SRC_LOCK];
  assign osc_irq   = flag_vec[SRC_OSC]  & ie_q[SRC_OSC];

  assert_lock_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_ENABLE && !wr_data[SRC_LOCK]) |=> !lock_irq);

  assert_osc_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_ENABLE && !wr_data[SRC_OSC]) |=> !osc_irq);

  assert_lock_to_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_st != $past(lock_st)) |=> lock_flag);
endmodule

// File: tb/clkmon_irq_unit_bench.sv
module clkmon_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock_raw = 1'b0, osc_en = 1'b0, full_stop = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic       lock_st, osc_rdy, lock_flag, osc_flag, lock_irq, osc_irq;
  int         n_checks = 0;
  int         n_errors = 0;

  always #10 clk = ~clk;

  clkmon_irq_unit u_clkmon_irq_unit (
    .clk(clk), .rst_n(rst_n), .lock_raw(lock_raw), .osc_en(osc_en),
    .full_stop(full_stop), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lock_st(lock_st), .osc_rdy(osc_rdy), .lock_flag(lock_flag),
    .osc_flag(osc_flag), .lock_irq(lock_irq), .osc_irq(osc_irq)
  );

  // inputs {lock,en,stop,wr,sel,wd1,wd0} _ expected {st,osc,lf,of,li,oi}
  localparam int NV = 24;
  localparam logic [12:0] VEC [NV] = '{
    13'b0000000_000000, 13'b1101000_000000, 13'b1100000_100000,
    13'b1100000_111000, 13'b1100000_111100, 13'b1101011_111111,
    13'b1101101_110101, 13'b1101110_110000, 13'b0100000_110000,
    13'b0100000_010000, 13'b0100000_011010, 13'b0000000_001010,
    13'b0000000_001111, 13'b0001111_000000, 13'b0100000_000000,
    13'b0100000_000000, 13'b1100000_000000, 13'b1100000_100000,
    13'b1100000_111010, 13'b1101110_111111, 13'b1110000_101111,
    13'b1111111_100101, 13'b1101000_110100, 13'b1100000_110100
  };

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [6:0] v);
    {lock_raw, osc_en, full_stop, wr_en, wr_sel, wr_data} = v;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 status", {lock_st, osc_rdy}, 2'b00);
    chk("R1 flags",  {lock_flag, osc_flag}, 2'b00);
    chk("R1 irqs",   {lock_irq, osc_irq}, 2'b00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][12:6]);
      @(negedge clk);
      chk($sformatf("R2 row%0d lock_st", i), {1'b0, lock_st}, {1'b0, VEC[i][5]});
      chk($sformatf("R7 R8 row%0d osc_rdy", i), {1'b0, osc_rdy}, {1'b0, VEC[i][4]});
      chk($sformatf("R3 R9 R5 R4 row%0d flags", i), {lock_flag, osc_flag}, VEC[i][3:2]);
      chk($sformatf("R6 row%0d irqs", i), {lock_irq, osc_irq}, VEC[i][1:0]);
    end

    // R4: clear write with zero data leaves the oscillator flag set
    drive(7'b1101100);
    @(negedge clk);
    chk("R4 zero-bit clear", {lock_flag, osc_flag}, 2'b01);

    // R6: enabling only the oscillator source raises only its request
    drive(7'b1101010);
    @(negedge clk);
    chk("R6 osc enable only", {lock_irq, osc_irq}, 2'b01);

    // R1: mid-run reset clears everything, including enables
    drive(7'b1100000);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset status", {lock_st, osc_rdy}, 2'b00);
    chk("R1 reset flags",  {lock_flag, osc_flag}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 R6 flags after reset", {lock_flag, osc_flag}, 2'b11);
    chk("R1 R6 enables cleared", {lock_irq, osc_irq}, 2'b00);

    finish_run();
  end
endmodule